// File: doc/BRIEF.md
# MDIO Management Slave with PHY Register File

This block is the management end of a PHY: it listens to a two-wire serial management bus made of a clock (MDC) and a shared data line (MDIO). It decodes read and write frames, acts only on frames carrying its own port address, and answers reads by taking the data line through the turnaround and 16 data bits. Behind the bus sits a small register file: a control word, a status word, two identification words and an extended control word. Together they hold the port address, an override bit and the live or latched status inputs.

The logic runs entirely on MDC. An active-low hardware reset captures the strapped port address and loads every register with its default. Writing bit 15 of the control word performs a software reset, which restores the same defaults but keeps the captured address. The loopback and isolate control bits are driven out as pins. Isolate defaults to 1 exactly when the captured address is zero.

Top module: `mdio_phy_regs`

## Requirements
- R1: A frame is accepted after 32 consecutive ones, a start pair 0 then 1, an opcode (10 read, 01 write), a 5-bit port address and a 5-bit register address. For a matching read, the data line is not driven during the bit after the register address. During the next bit it is driven to 0. The 16 register bits then follow MSB first, each changing after a rising MDC edge, and the line is released after the last one.
- R2: A frame whose port address differs from the stored address is not answered (the output enable stays low) and its write changes no register.
- R3: A write to control register 0 stores bits 14 (loopback), 13, 12, 10 (isolate) and 8. All other bits of register 0 read 0. After hardware reset, register 0 holds bits 13 and 12 set.
- R4: Output loopback follows control bit 14 and output isolate follows control bit 10.
- R5: After hardware reset, control bit 10 and the isolate output are 1 when the strapped address is 00000 and 0 otherwise.
- R6: Writing register 0 with bit 15 set pulses sw_reset high for exactly one MDC cycle. It returns every register to its default, except the captured address, and bit 15 reads back 0.
- R7: Registers 2 and 3 always read their identification values. A write to them takes effect only while register 16 bit 15 (override) is 1.
- R8: Status bit 1.6 (accept frames without preamble) resets to 0 and is written only while override is 1. While it is 1, a frame starting directly with the start pair is served. While it is 0, such a frame is ignored.
- R9: Status bit 1.1 (jabber) and bit 1.4 (remote fault) go to 1 on their event input and stay 1 until register 1 has been read. Bit 1.2 shows link_up live. Bits 15:11 read 11110, bits 3 and 0 read 1, and the other bits read 0.
- R10: Register 16 reads override at bit 15 and the captured address at bits 10:6, with all other bits 0.
- R11: Register addresses other than 0, 1, 2, 3 and 16 read as all zeros, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; every bit is sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| mdio_i | input | 1 | Data line as seen at the pad |
| mdio_o | output | 1 | Data value driven during a read |
| mdio_oe | output | 1 | Drive enable for the data line |
| strap_addr | input | 5 | Port address captured at hardware reset |
| link_up | input | 1 | Live link state shown in status bit 2 |
| jabber_evt | input | 1 | Jabber event, latched into status bit 1 |
| rfault_evt | input | 1 | Remote fault event, latched into status bit 4 |
| sw_reset | output | 1 | One-cycle software reset pulse |
| loopback | output | 1 | Loopback control |
| isolate | output | 1 | Isolate control |

## Verification
The assertions assume that the event inputs and mdio_i change only away from the rising MDC edge. They also assume that the station never drives a new frame while the slave is still inside the body of the previous one. The bench meets both assumptions: it changes every input on the falling edge, and it sends frames strictly back to back, leaving at least one idle bit between them. The random part picks register addresses from a set that mixes the implemented and unimplemented addresses. It clears bit 15 of random control data, so that a software reset happens only in the directed case.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [1:0] {S_IDLE, S_START, S_HDR, S_BODY} mdio_state_e;

  localparam logic [1:0]  OP_RD = 2'b10;
  localparam logic [1:0]  OP_WR = 2'b01;
  localparam logic [4:0]  REG_CTL = 5'd0;
  localparam logic [4:0]  REG_STS = 5'd1;
  localparam logic [4:0]  REG_ID1 = 5'd2;
  localparam logic [4:0]  REG_ID2 = 5'd3;
  localparam logic [4:0]  REG_EXT = 5'd16;
  localparam logic [15:0] CTL_WMASK = 16'h7500;
  localparam int B_RST    = 15;
  localparam int B_LOOP   = 14;
  localparam int B_ISO    = 10;
  localparam int B_PRESUP = 6;
  localparam int B_OVR    = 15;

  function automatic logic [15:0] ctl_default(input logic [4:0] addr);
    logic [15:0] v;
    v = '0;
    v[13] = 1'b1;
    v[12] = 1'b1;
    v[B_ISO] = (addr == 5'd0);
    return v;
  endfunction

  function automatic logic reg_implemented(input logic [4:0] a);
    return (a == REG_CTL) || (a == REG_STS) || (a == REG_ID1) ||
           (a == REG_ID2) || (a == REG_EXT);
  endfunction

  function automatic logic preamble_met(input int unsigned ones,
                                        input int unsigned need,
                                        input logic sup);
    return sup || (ones >= need);
  endfunction

  function automatic logic lh_next(input logic cur, input logic evt, input logic clr);
    return (cur & ~clr) | evt;
  endfunction
endpackage

// File: rtl/mdio_frame_rx.sv
module mdio_frame_rx
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int DW      = 16
) (
  input  logic          mdc,
  input  logic          rst_n,
  input  logic          mdio_i,
  input  logic [4:0]    phy_addr,
  input  logic          presup,
  input  logic [DW-1:0] rd_word,
  output logic          mdio_o,
  output logic          mdio_oe,
  output logic          hdr_done,
  output logic          hdr_read,
  output logic [4:0]    hdr_reg,
  output logic          wr_stb,
  output logic [4:0]    wr_reg,
  output logic [DW-1:0] wr_data
);
  localparam int PW        = $clog2(PRE_LEN + 1);
  localparam int HDR_BITS  = 12;
  localparam int BODY_LAST = DW + 1;
  localparam int CW        = $clog2(BODY_LAST + 1);

  mdio_state_e         st_q;
  logic [PW-1:0]       ones_q;
  logic [CW-1:0]       cnt_q;
  logic [HDR_BITS-2:0] hdr_q;
  logic [DW-1:0]       sh_q;
  logic                rd_q, wr_q;
  logic [4:0]          reg_q;

  logic [HDR_BITS-1:0] hdr_w;
  logic [1:0]          op;
  logic                match, hdr_valid, hdr_write, body_end, pre_ok;

  assign hdr_w     = {hdr_q, mdio_i};
  assign op        = hdr_w[11:10];
  assign hdr_reg   = hdr_w[4:0];
  assign match     = (hdr_w[9:5] == phy_addr);
  assign hdr_done  = (st_q == S_HDR) && (cnt_q == CW'(HDR_BITS - 1));
  assign hdr_valid = (op == OP_RD) || (op == OP_WR);
  assign hdr_read  = hdr_done && match && (op == OP_RD);
  assign hdr_write = hdr_done && match && (op == OP_WR);
  assign body_end  = (st_q == S_BODY) && (cnt_q == CW'(BODY_LAST));
  assign pre_ok    = preamble_met(32'(ones_q), 32'(PRE_LEN), presup);

  assign wr_stb  = body_end && wr_q;
  assign wr_reg  = reg_q;
  assign wr_data = {sh_q[DW-2:0], mdio_i};

  // cnt 0: first turnaround bit (released), cnt 1: driven zero, cnt 2..: data
  assign mdio_oe = (st_q == S_BODY) && rd_q && (cnt_q != '0);
  assign mdio_o  = mdio_oe && (cnt_q != CW'(1)) && sh_q[DW-1];

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      ones_q <= '0;
      cnt_q  <= '0;
      hdr_q  <= '0;
      sh_q   <= '0;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      reg_q  <= '0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (mdio_i) begin
            if (ones_q != PW'(PRE_LEN)) ones_q <= ones_q + 1'b1;
          end else begin
            ones_q <= '0;
            if (pre_ok) st_q <= S_START;
          end
        end
        S_START: begin
          cnt_q <= '0;
          st_q  <= mdio_i ? S_HDR : S_IDLE;
        end
        S_HDR: begin
          hdr_q <= hdr_w[HDR_BITS-2:0];
          cnt_q <= cnt_q + 1'b1;
          if (hdr_done) begin
            cnt_q <= '0;
            if (hdr_valid) begin
              st_q  <= S_BODY;
              rd_q  <= hdr_read;
              wr_q  <= hdr_write;
              reg_q <= hdr_reg;
              if (hdr_read) sh_q <= rd_word;
            end else begin
              st_q <= S_IDLE;
            end
          end
        end
        S_BODY: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q >= CW'(2)) begin
            if (rd_q) sh_q <= {sh_q[DW-2:0], 1'b0};
            else      sh_q <= wr_data;
          end
          if (body_end) begin
            st_q  <= S_IDLE;
            cnt_q <= '0;
            rd_q  <= 1'b0;
            wr_q  <= 1'b0;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter logic [15:0] ID_HI   = 16'h0015,
  parameter logic [15:0] ID_LO   = 16'hF450,
  parameter logic [4:0]  ABILITY = 5'b11110,
  parameter int          N_LH    = 2
) (
  input  logic        mdc,
  input  logic        rst_n,
  input  logic [4:0]  strap_addr,
  input  logic        link_up,
  input  logic [N_LH-1:0] lh_evt,
  input  logic        rd_fire,
  input  logic [4:0]  rd_reg,
  input  logic        wr_stb,
  input  logic [4:0]  wr_reg,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_word,
  output logic [4:0]  phy_addr,
  output logic        presup,
  output logic        ovr,
  output logic        sw_reset,
  output logic        loopback,
  output logic        isolate,
  output logic [N_LH-1:0] lh_bits,
  output logic [15:0] id_hi
);
  logic [4:0]  addr_q;
  logic [15:0] ctl_q, id_hi_q, id_lo_q;
  logic        ovr_q, sup_q, swr_q;
  logic        soft_go, sts_clr;

  assign soft_go = wr_stb && (wr_reg == REG_CTL) && wr_data[B_RST];
  assign sts_clr = rd_fire && (rd_reg == REG_STS);

  // latching-high status bits: index 0 jabber, index 1 remote fault
  for (genvar i = 0; i < N_LH; i++) begin : g_lh
    logic lh_q;
    always_ff @(posedge mdc or negedge rst_n) begin
      if (!rst_n)       lh_q <= 1'b0;
      else if (soft_go) lh_q <= 1'b0;
      else              lh_q <= lh_next(lh_q, lh_evt[i], sts_clr);
    end
    assign lh_bits[i] = lh_q;
  end

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= strap_addr;
      ctl_q   <= ctl_default(strap_addr);
      id_hi_q <= ID_HI;
      id_lo_q <= ID_LO;
      ovr_q   <= 1'b0;
      sup_q   <= 1'b0;
      swr_q   <= 1'b0;
    end else begin
      swr_q <= 1'b0;
      if (soft_go) begin
        swr_q   <= 1'b1;
        ctl_q   <= ctl_default(addr_q);
        id_hi_q <= ID_HI;
        id_lo_q <= ID_LO;
        ovr_q   <= 1'b0;
        sup_q   <= 1'b0;
      end else if (wr_stb) begin
        case (wr_reg)
          REG_CTL: ctl_q <= wr_data & CTL_WMASK;
          REG_STS: if (ovr_q) sup_q <= wr_data[B_PRESUP];
          REG_ID1: if (ovr_q) id_hi_q <= wr_data;
          REG_ID2: if (ovr_q) id_lo_q <= wr_data;
          REG_EXT: ovr_q <= wr_data[B_OVR];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_reg)
      REG_CTL: rd_word = ctl_q;
      REG_STS: rd_word = {ABILITY, 4'b0000, sup_q, 1'b0, lh_bits[1], 1'b1,
                          link_up, lh_bits[0], 1'b1};
      REG_ID1: rd_word = id_hi_q;
      REG_ID2: rd_word = id_lo_q;
      REG_EXT: rd_word = {ovr_q, 4'b0000, addr_q, 6'b000000};
      default: rd_word = '0;
    endcase
  end

  assign phy_addr = addr_q;
  assign presup   = sup_q;
  assign ovr      = ovr_q;
  assign sw_reset = swr_q;
  assign loopback = ctl_q[B_LOOP];
  assign isolate  = ctl_q[B_ISO];
  assign id_hi    = id_hi_q;
endmodule

// File: rtl/mdio_phy_regs.sv
module mdio_phy_regs
  import mdio_pkg::*;
#(
  parameter int          PRE_LEN = 32,
  parameter logic [15:0] ID_HI   = 16'h0015,
  parameter logic [15:0] ID_LO   = 16'hF450,
  parameter logic [4:0]  ABILITY = 5'b11110
) (
  input  logic       mdc,
  input  logic       rst_n,
  input  logic       mdio_i,
  output logic       mdio_o,
  output logic       mdio_oe,
  input  logic [4:0] strap_addr,
  input  logic       link_up,
  input  logic       jabber_evt,
  input  logic       rfault_evt,
  output logic       sw_reset,
  output logic       loopback,
  output logic       isolate
);
  localparam int DW   = 16;
  localparam int N_LH = 2;

  logic [DW-1:0]   rd_word, wr_data, id_hi;
  logic [4:0]      phy_addr, hdr_reg, wr_reg;
  logic            presup, ovr, hdr_done, hdr_read, wr_stb;
  logic [N_LH-1:0] lh_bits;

  mdio_frame_rx #(.PRE_LEN(PRE_LEN), .DW(DW)) u_rx (
    .mdc(mdc), .rst_n(rst_n), .mdio_i(mdio_i), .phy_addr(phy_addr),
    .presup(presup), .rd_word(rd_word), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .hdr_done(hdr_done), .hdr_read(hdr_read), .hdr_reg(hdr_reg),
    .wr_stb(wr_stb), .wr_reg(wr_reg), .wr_data(wr_data)
  );

  mdio_regs #(.ID_HI(ID_HI), .ID_LO(ID_LO), .ABILITY(ABILITY), .N_LH(N_LH)) u_regs (
    .mdc(mdc), .rst_n(rst_n), .strap_addr(strap_addr), .link_up(link_up),
    .lh_evt({rfault_evt, jabber_evt}), .rd_fire(hdr_read), .rd_reg(hdr_reg),
    .wr_stb(wr_stb), .wr_reg(wr_reg), .wr_data(wr_data), .rd_word(rd_word),
    .phy_addr(phy_addr), .presup(presup), .ovr(ovr), .sw_reset(sw_reset),
    .loopback(loopback), .isolate(isolate), .lh_bits(lh_bits), .id_hi(id_hi)
  );
endmodule

// File: rtl/mdio_sva.sv
module mdio_sva
  import mdio_pkg::*;
(
  input logic        mdc,
  input logic        rst_n,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        sw_reset,
  input logic        loopback,
  input logic        hdr_done,
  input logic [4:0]  hdr_reg,
  input logic [15:0] rd_word,
  input logic        jabber_evt,
  input logic [1:0]  lh_bits,
  input logic        wr_stb,
  input logic [4:0]  wr_reg,
  input logic        ovr,
  input logic [15:0] id_hi
);
  // R1: the first driven turnaround bit is zero
  assert_ta_zero_R1: assert property (@(posedge mdc) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);

  // R6: software reset is a single-cycle pulse
  assert_swr_pulse_R6: assert property (@(posedge mdc) disable iff (!rst_n)
    sw_reset |=> !sw_reset);

  // R6: defaults are in place while the pulse is high
  assert_swr_default_R6: assert property (@(posedge mdc) disable iff (!rst_n)
    sw_reset |-> !loopback);

  // R11: unimplemented addresses give zero read data
  assert_unimpl_zero_R11: assert property (@(posedge mdc) disable iff (!rst_n)
    (hdr_done && !reg_implemented(hdr_reg)) |-> (rd_word == 16'h0000));

  // R9: a jabber event leaves the latched bit set
  assert_lh_set_R9: assert property (@(posedge mdc) disable iff (!rst_n)
    (jabber_evt && !(wr_stb && wr_reg == REG_CTL)) |=> lh_bits[0]);

  // R7: identification writes without override change nothing
  assert_id_locked_R7: assert property (@(posedge mdc) disable iff (!rst_n)
    (wr_stb && wr_reg == REG_ID1 && !ovr) |=> $stable(id_hi));
endmodule

bind mdio_phy_regs mdio_sva u_sva (
  .mdc(mdc), .rst_n(rst_n), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .sw_reset(sw_reset), .loopback(loopback), .hdr_done(hdr_done),
  .hdr_reg(hdr_reg), .rd_word(rd_word), .jabber_evt(jabber_evt),
  .lh_bits(lh_bits), .wr_stb(wr_stb), .wr_reg(wr_reg), .ovr(ovr), .id_hi(id_hi)
);

// File: tb/mdio_phy_regs_bench.sv
module mdio_phy_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] E_ID1 = 16'h0015;
  localparam logic [15:0] E_ID2 = 16'hF450;

  logic mdc = 1'b0;
  logic rst_n = 1'b0;
  logic mdio_i = 1'b1;
  logic [4:0] strap = 5'h05;
  logic link_up = 1'b1, jabber_evt = 1'b0, rfault_evt = 1'b0;
  logic mdio_o, mdio_oe, sw_reset, loopback, isolate;
  int checks = 0, errors = 0;

  // bench-side model
  logic [15:0] m_ctl, m_id1, m_id2;
  logic m_ovr, m_sup, m_jab, m_rf;
  logic [4:0] m_addr;

  always #(CLK_PERIOD/2) mdc = ~mdc;

  mdio_phy_regs u_mdio_phy_regs (
    .mdc(mdc), .rst_n(rst_n), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .strap_addr(strap), .link_up(link_up), .jabber_evt(jabber_evt),
    .rfault_evt(rfault_evt), .sw_reset(sw_reset), .loopback(loopback), .isolate(isolate)
  );

  function automatic logic [15:0] ctl_reset_value(input logic [4:0] a);
    return 16'h3000 | ((a == 5'd0) ? 16'h0400 : 16'h0000);
  endfunction

  function automatic logic [15:0] exp_read(input logic [4:0] r);
    case (r)
      5'd0:  return m_ctl;
      5'd1:  return {5'b11110, 4'b0, m_sup, 1'b0, m_rf, 1'b1, link_up, m_jab, 1'b1};
      5'd2:  return m_id1;
      5'd3:  return m_id2;
      5'd16: return {m_ovr, 4'b0, m_addr, 6'b0};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic m_defaults();
    m_ctl = ctl_reset_value(m_addr);
    m_id1 = E_ID1; m_id2 = E_ID2;
    m_ovr = 1'b0; m_sup = 1'b0; m_jab = 1'b0; m_rf = 1'b0;
  endtask

  task automatic m_write(input logic [4:0] r, input logic [15:0] d);
    case (r)
      5'd0:  if (d[15]) m_defaults(); else m_ctl = d & 16'h7500;
      5'd1:  if (m_ovr) m_sup = d[6];
      5'd2:  if (m_ovr) m_id1 = d;
      5'd3:  if (m_ovr) m_id2 = d;
      5'd16: m_ovr = d[15];
      default: ;
    endcase
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic b);
    @(negedge mdc);
    mdio_i = b;
  endtask

  task automatic header(input logic pre, input logic [1:0] op,
                        input logic [4:0] phy, input logic [4:0] r);
    if (pre) for (int i = 0; i < 32; i++) send(1'b1);
    send(1'b0); send(1'b1);
    for (int i = 1; i >= 0; i--) send(op[i]);
    for (int i = 4; i >= 0; i--) send(phy[i]);
    for (int i = 4; i >= 0; i--) send(r[i]);
  endtask

  task automatic do_write(input logic pre, input logic [4:0] phy,
                          input logic [4:0] r, input logic [15:0] d);
    header(pre, 2'b01, phy, r);
    send(1'b1); send(1'b0);
    for (int i = 15; i >= 0; i--) send(d[i]);
    send(1'b1);
  endtask

  task automatic do_read(input logic pre, input logic [4:0] phy, input logic [4:0] r,
                         output logic [15:0] d, output logic ok, output logic any_oe);
    header(pre, 2'b10, phy, r);
    ok = 1'b1; any_oe = 1'b0; d = '0;
    @(negedge mdc); mdio_i = 1'b1;
    if (mdio_oe) begin ok = 1'b0; any_oe = 1'b1; end
    @(negedge mdc);
    any_oe |= mdio_oe;
    if (!(mdio_oe && !mdio_o)) ok = 1'b0;
    for (int i = 0; i < 16; i++) begin
      @(negedge mdc);
      any_oe |= mdio_oe;
      if (!mdio_oe) ok = 1'b0;
      d = {d[14:0], mdio_o};
    end
    @(negedge mdc);
    if (mdio_oe) begin ok = 1'b0; any_oe = 1'b1; end
  endtask

  task automatic rd_check(input string req, input logic [4:0] r);
    logic [15:0] d; logic ok, ao;
    do_read(1'b1, m_addr, r, d, ok, ao);
    check(req, d, exp_read(r));
    check("R1 read timing", {15'b0, ok}, 16'h0001);
    if (r == 5'd1) begin m_jab = 1'b0; m_rf = 1'b0; end
  endtask

  task automatic hw_reset(input logic [4:0] a);
    @(negedge mdc);
    rst_n = 1'b0; strap = a; mdio_i = 1'b1;
    @(negedge mdc); @(negedge mdc);
    rst_n = 1'b1;
    m_addr = a;
    m_defaults();
  endtask

  initial begin
    repeat (150000) @(posedge mdc);
    errors++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d; logic ok, ao;
    void'($urandom(32'd4242));
    hw_reset(5'h05);
    // R5 reset state, nonzero address
    check("R5 isolate after reset", {15'b0, isolate}, 16'h0000);
    check("R4 loopback after reset", {15'b0, loopback}, 16'h0000);
    rd_check("R3 ctl default", 5'd0);
    rd_check("R7 id1 read", 5'd2);
    rd_check("R7 id2 read", 5'd3);
    rd_check("R10 ext reg", 5'd16);
    rd_check("R9 status default", 5'd1);

    // R3 / R4 write control, reserved bits dropped
    do_write(1'b1, m_addr, 5'd0, 16'h7FFF); m_write(5'd0, 16'h7FFF);
    check("R4 loopback set", {15'b0, loopback}, 16'h0001);
    check("R4 isolate set", {15'b0, isolate}, 16'h0001);
    rd_check("R3 ctl masked", 5'd0);

    // R2 wrong address: no drive, no write
    do_read(1'b1, 5'h06, 5'd0, d, ok, ao);
    check("R2 no drive on other address", {15'b0, ao}, 16'h0000);
    do_write(1'b1, 5'h06, 5'd0, 16'h0000);
    rd_check("R2 write to other address ignored", 5'd0);

    // R7 ID writes locked then unlocked
    do_write(1'b1, m_addr, 5'd2, 16'hBEEF); m_write(5'd2, 16'hBEEF);
    rd_check("R7 id locked", 5'd2);
    do_write(1'b1, m_addr, 5'd16, 16'h8000); m_write(5'd16, 16'h8000);
    rd_check("R10 override readback", 5'd16);
    do_write(1'b1, m_addr, 5'd3, 16'hCAFE); m_write(5'd3, 16'hCAFE);
    rd_check("R7 id written under override", 5'd3);

    // R8 preamble suppression
    do_write(1'b1, m_addr, 5'd16, 16'h0000); m_write(5'd16, 16'h0000);
    do_write(1'b1, m_addr, 5'd1, 16'h0040); m_write(5'd1, 16'h0040);
    rd_check("R8 presup locked", 5'd1);
    do_read(1'b0, m_addr, 5'd2, d, ok, ao);
    check("R8 no preamble ignored", {15'b0, ao}, 16'h0000);
    do_write(1'b1, m_addr, 5'd16, 16'h8000); m_write(5'd16, 16'h8000);
    do_write(1'b1, m_addr, 5'd1, 16'h0040); m_write(5'd1, 16'h0040);
    rd_check("R8 presup set", 5'd1);
    do_read(1'b0, m_addr, 5'd2, d, ok, ao);
    check("R8 no preamble served", d, m_id1);
    check("R8 no preamble timing", {15'b0, ok}, 16'h0001);

    // R9 latching status
    @(negedge mdc); jabber_evt = 1'b1;
    @(negedge mdc); jabber_evt = 1'b0; rfault_evt = 1'b1;
    @(negedge mdc); rfault_evt = 1'b0; link_up = 1'b0;
    m_jab = 1'b1; m_rf = 1'b1;
    repeat (3) @(negedge mdc);
    rd_check("R9 latched bits held", 5'd1);
    rd_check("R9 latched bits cleared by read", 5'd1);
    link_up = 1'b1;
    rd_check("R9 link live", 5'd1);

    // R11 unimplemented addresses
    do_write(1'b1, m_addr, 5'd9, 16'hFFFF); m_write(5'd9, 16'hFFFF);
    rd_check("R11 unimplemented read zero", 5'd9);
    rd_check("R11 unimplemented address 31", 5'd31);

    // R6 software reset
    do_write(1'b1, m_addr, 5'd0, 16'hC000); m_write(5'd0, 16'hC000);
    check("R6 sw_reset pulse", {15'b0, sw_reset}, 16'h0001);
    @(negedge mdc);
    check("R6 sw_reset one cycle", {15'b0, sw_reset}, 16'h0000);
    check("R6 loopback default", {15'b0, loopback}, 16'h0000);
    rd_check("R6 ctl default bit15 clear", 5'd0);
    rd_check("R6 ids restored", 5'd3);
    rd_check("R6 address kept", 5'd16);
    rd_check("R6 presup cleared", 5'd1);

    // random traffic against the model
    for (int n = 0; n < 60; n++) begin
      logic [4:0] r; logic [15:0] v; int pick;
      pick = $urandom_range(0, 7);
      case (pick)
        0: r = 5'd0; 1: r = 5'd1; 2: r = 5'd2; 3: r = 5'd3;
        4: r = 5'd16; 5: r = 5'd4; 6: r = 5'd9; default: r = 5'd31;
      endcase
      v = 16'($urandom);
      if (r == 5'd0) v[15] = 1'b0;
      do_write(1'b1, m_addr, r, v); m_write(r, v);
      rd_check("R3 R7 R11 random readback", r);
      if (r == 5'd0) check("R4 random loopback", {15'b0, loopback}, {15'b0, m_ctl[14]});
    end

    // R5 address zero
    hw_reset(5'h00);
    check("R5 isolate at address zero", {15'b0, isolate}, 16'h0001);
    rd_check("R5 ctl isolate default", 5'd0);
    do_read(1'b1, 5'h05, 5'd0, d, ok, ao);
    check("R2 old address ignored", {15'b0, ao}, 16'h0000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule